// File: doc/BRIEF.md
# Flash Command Sequencer

This block sits between a host write bus and the control side of a block-erasable NOR flash. Every bus write delivers an address and a command or data byte. The block decodes that stream into the flash command set. It tracks which read mode the data path should present: array contents, identifier codes, query table or the status register. It also follows the multi-cycle sequences for erase, program, buffered program and lock-bit changes.

When a sequence completes and passes the protection checks, the block sends a one-cycle start request to an external write engine. The request carries the operation kind, target address, data byte and buffer length. The block then waits for that engine's done pulse. It holds the 8-bit status register. It applies per-block lock bits, a master lock bit and a high-voltage override. It supports suspending a running erase so that reads can proceed.

Top module: `flash_cmd_seq`

## Requirements
- R1: While `rst` is high, and on the first cycle after it falls, `read_mode` is 0 (array), `status` is 0x80, `op_start` is low, `op_hold` is low and all lock bits are clear.
- R2: When idle, writing 0xFF selects array mode (read_mode 0), 0x90 selects identifier mode (1), 0x98 selects query mode (2) and 0x70 selects status mode (3). Any other single byte leaves the mode unchanged, except the cases in R3 to R6 and R10.
- R3: Writing 0x20 and then 0xD0 raises `op_start` for one cycle, on the clock after the second write. `op_kind` is 1 (erase) and `op_addr` is the address of the 0xD0 write. The first write of any multi-cycle sequence switches `read_mode` to 3.
- R4: Writing 0x40 or 0x10 and then any byte raises `op_start` with `op_kind` 2 (program). `op_addr` and `op_data` are the address and byte of that second write.
- R5: A write of 0x60 followed by 0x01 launches kind 4, which sets the lock bit of the addressed block. 0x60 followed by 0xD0 launches kind 5, which clears all block lock bits. 0x60 followed by 0xF1 launches kind 6, which sets the master lock bit. Each lock change is applied when `eng_done` ends the operation.
- R6: A write of 0xE8 is followed by a count byte N, then N+1 data writes, then 0xD0. Data bytes may hold any value, including 0xD0. This sequence launches kind 3 with `op_len` = N+1 and `op_addr` = the address of the 0xE8 write. If N+1 exceeds BUF_BYTES, the count write instead sets status bits 5 and 4.
- R7: An erase, program or buffered program aimed at a locked block is refused when `hv_override` is low. It sets status bit 1 together with bit 5 for erase, or bit 4 for a program. A set master lock refuses set-lock (bit 4) and clear-locks (bit 5) without the override. Setting the master lock itself always needs the override.
- R8: If `prog_en` is low when a launch is attempted, nothing starts. Status bit 3 is set, together with bit 5 for erase or clear-locks, or bit 4 otherwise.
- R9: Status bit 7 is 0 from the launch until `eng_done` arrives, and 1 otherwise.
- R10: An unrecognised second cycle, whether after 0x20, after 0x60 or in place of the final 0xD0 of a buffered program, sets status bits 5 and 4. It starts nothing and sets `read_mode` to 3.
- R11: Error bits 5, 4, 3 and 1 stay set until an idle write of 0x50 clears them.
- R12: 0xB0 written during an erase raises `op_hold` and makes status read 0xC0. While the erase is suspended, read-mode commands take effect. 0xD0 resumes the erase, drops `op_hold` and selects mode 3. 0xB0 written during any other operation has no effect.
- R13: While an operation runs and is not suspended, every write other than R12's suspend leaves `read_mode`, `status` and the lock state unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; aborts any operation |
| wr_en | input | 1 | Bus write strobe, one cycle per write |
| wr_addr | input | ADDR_W | Byte address of the write; top BLK_W bits select the block |
| wr_data | input | 8 | Command or data byte |
| prog_en | input | 1 | High when the programming supply is above lockout |
| hv_override | input | 1 | High-voltage override of lock protection |
| eng_done | input | 1 | One-cycle completion pulse from the write engine |
| read_mode | output | 2 | 0 array, 1 identifier, 2 query, 3 status |
| op_start | output | 1 | One-cycle operation request |
| op_kind | output | 3 | 1 erase, 2 program, 3 buffered program, 4 set block lock, 5 clear locks, 6 set master lock |
| op_addr | output | ADDR_W | Target address of the operation |
| op_data | output | 8 | Program byte |
| op_len | output | LEN_W | Byte count of a buffered program |
| op_hold | output | 1 | Erase suspended; engine must freeze |
| status | output | 8 | Status register |

## Verification
The bench builds the block with a 20-bit address, eight blocks and an 8-byte buffer. The small buffer means the largest allowed count (7) and the first rejected count (8) both fit in a short run. Eight blocks keep the lock tests on distinct blocks that are cheap to address. The bench also acts as the write engine: it issues done pulses by hand. This lets it observe busy status, suspend and resume, ignored writes during an operation, and lock changes taking effect only at completion.

// File: rtl/fcs_pkg.sv
package fcs_pkg;

    localparam logic [7:0] CMD_RD_ARRAY  = 8'hFF;
    localparam logic [7:0] CMD_RD_IDENT  = 8'h90;
    localparam logic [7:0] CMD_RD_QUERY  = 8'h98;
    localparam logic [7:0] CMD_RD_STATUS = 8'h70;
    localparam logic [7:0] CMD_CLR_SR    = 8'h50;
    localparam logic [7:0] CMD_SUSPEND   = 8'hB0;
    localparam logic [7:0] CMD_CONFIRM   = 8'hD0;
    localparam logic [7:0] CMD_ERASE     = 8'h20;
    localparam logic [7:0] CMD_PROG_A    = 8'h40;
    localparam logic [7:0] CMD_PROG_B    = 8'h10;
    localparam logic [7:0] CMD_LOCK      = 8'h60;
    localparam logic [7:0] CMD_BUF       = 8'hE8;
    localparam logic [7:0] SUB_SET_BLK   = 8'h01;
    localparam logic [7:0] SUB_SET_MST   = 8'hF1;

    localparam logic [7:0] SRB_ERASE_ERR = 8'h20;
    localparam logic [7:0] SRB_PROG_ERR  = 8'h10;
    localparam logic [7:0] SRB_SUPPLY    = 8'h08;
    localparam logic [7:0] SRB_LOCKED    = 8'h02;
    localparam logic [7:0] SRB_STICKY    = 8'h3A;

    typedef enum logic [1:0] {
        RM_ARRAY  = 2'd0,
        RM_IDENT  = 2'd1,
        RM_QUERY  = 2'd2,
        RM_STATUS = 2'd3
    } rmode_t;

    typedef enum logic [2:0] {
        OP_NONE      = 3'd0,
        OP_ERASE     = 3'd1,
        OP_PROG      = 3'd2,
        OP_BUFPROG   = 3'd3,
        OP_SETLK     = 3'd4,
        OP_CLRLK     = 3'd5,
        OP_SETMASTER = 3'd6
    } op_kind_t;

    typedef enum logic [2:0] {
        SQ_IDLE, SQ_ERASE, SQ_PROG, SQ_LOCK, SQ_BUFCNT, SQ_BUFDATA, SQ_BUFCONF
    } seq_t;

    typedef enum logic [3:0] {
        CC_RDARR, CC_IDENT, CC_QUERY, CC_RDSR, CC_CLRSR, CC_SUSP, CC_CONFIRM,
        CC_ERASE, CC_PROG, CC_LOCK, CC_BUF, CC_OTHER
    } cmd_class_t;

    function automatic cmd_class_t classify(input logic [7:0] b);
        case (b)
            CMD_RD_ARRAY:         return CC_RDARR;
            CMD_RD_IDENT:         return CC_IDENT;
            CMD_RD_QUERY:         return CC_QUERY;
            CMD_RD_STATUS:        return CC_RDSR;
            CMD_CLR_SR:           return CC_CLRSR;
            CMD_SUSPEND:          return CC_SUSP;
            CMD_CONFIRM:          return CC_CONFIRM;
            CMD_ERASE:            return CC_ERASE;
            CMD_PROG_A, CMD_PROG_B: return CC_PROG;
            CMD_LOCK:             return CC_LOCK;
            CMD_BUF:              return CC_BUF;
            default:              return CC_OTHER;
        endcase
    endfunction

    // Failure class bit reported when an operation of this kind is refused
    function automatic logic [7:0] fail_bit(input op_kind_t k);
        return (k == OP_ERASE || k == OP_CLRLK) ? SRB_ERASE_ERR : SRB_PROG_ERR;
    endfunction

endpackage

// File: rtl/fcs_status.sv
module fcs_status
    import fcs_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic [7:0] set_bits,
    input  logic       clr_err,
    input  logic       busy,
    input  logic       susp,
    output logic [7:0] sr
);

    logic [7:0] err_q;

    always_ff @(posedge clk) begin
        if (rst)          err_q <= '0;
        else if (clr_err) err_q <= set_bits & SRB_STICKY;
        else              err_q <= err_q | (set_bits & SRB_STICKY);
    end

    assign sr = (err_q & SRB_STICKY) | {(~busy) | susp, susp, 6'b0};

    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
        (sr[5] && !clr_err) |=> sr[5]); // R11

endmodule

// File: rtl/fcs_lock_table.sv
module fcs_lock_table #(
    parameter int NBLK = 32,
    parameter int IW   = $clog2(NBLK)
)(
    input  logic          clk,
    input  logic          rst,
    input  logic [IW-1:0] q_idx,
    output logic          q_locked,
    input  logic [IW-1:0] u_idx,
    input  logic          set_blk,
    input  logic          clr_all,
    input  logic          set_master,
    output logic          master
);

    logic [NBLK-1:0] lk_vec;
    logic            master_q;

    for (genvar g = 0; g < NBLK; g++) begin : g_blk
        logic bit_q;
        always_ff @(posedge clk) begin
            if (rst || clr_all)                      bit_q <= 1'b0;
            else if (set_blk && u_idx == IW'(g))     bit_q <= 1'b1;
        end
        assign lk_vec[g] = bit_q;
    end

    always_ff @(posedge clk) begin
        if (rst)             master_q <= 1'b0;
        else if (set_master) master_q <= 1'b1;
    end

    assign q_locked = lk_vec[q_idx];
    assign master   = master_q;

    AST_MASTER_STICKY: assert property (@(posedge clk) disable iff (rst)
        master |=> master); // R7
    AST_CLEAR_ALL: assert property (@(posedge clk) disable iff (rst)
        (clr_all && !set_blk) |=> (lk_vec == '0)); // R5

endmodule

// File: rtl/flash_cmd_seq.sv
module flash_cmd_seq
    import fcs_pkg::*;
#(
    parameter int ADDR_W    = 22,
    parameter int NBLK      = 32,
    parameter int BUF_BYTES = 32,
    localparam int BLK_W    = $clog2(NBLK),
    localparam int LEN_W    = $clog2(BUF_BYTES + 1)
)(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [7:0]        wr_data,
    input  logic              prog_en,
    input  logic              hv_override,
    input  logic              eng_done,
    output logic [1:0]        read_mode,
    output logic              op_start,
    output logic [2:0]        op_kind,
    output logic [ADDR_W-1:0] op_addr,
    output logic [7:0]        op_data,
    output logic [LEN_W-1:0]  op_len,
    output logic              op_hold,
    output logic [7:0]        status
);

    seq_t              seq_q, seq_d;
    rmode_t            mode_q, mode_d;
    op_kind_t          kind_q;
    logic              running_q, running_d, susp_q, susp_d, start_q;
    logic [ADDR_W-1:0] addr_q, bufaddr_q, bufaddr_d;
    logic [7:0]        data_q;
    logic [LEN_W-1:0]  len_q, left_q, left_d, buflen_q, buflen_d;

    cmd_class_t        cc;
    logic              seq_err, try_launch, go, clr_err, denied;
    op_kind_t          try_kind;
    logic [ADDR_W-1:0] try_addr;
    logic [LEN_W-1:0]  try_len;
    logic [7:0]        set_bits;
    logic              upd_set, upd_clr, upd_master;
    logic              lk_hit, master_lk;

    fcs_lock_table #(.NBLK(NBLK), .IW(BLK_W)) u_locks (
        .clk        (clk),
        .rst        (rst),
        .q_idx      (try_addr[ADDR_W-1 -: BLK_W]),
        .q_locked   (lk_hit),
        .u_idx      (addr_q[ADDR_W-1 -: BLK_W]),
        .set_blk    (upd_set),
        .clr_all    (upd_clr),
        .set_master (upd_master),
        .master     (master_lk)
    );

    fcs_status u_status (
        .clk      (clk),
        .rst      (rst),
        .set_bits (set_bits),
        .clr_err  (clr_err),
        .busy     (running_q),
        .susp     (susp_q),
        .sr       (status)
    );

    always_comb begin
        seq_d      = seq_q;
        mode_d     = mode_q;
        running_d  = running_q;
        susp_d     = susp_q;
        left_d     = left_q;
        buflen_d   = buflen_q;
        bufaddr_d  = bufaddr_q;
        seq_err    = 1'b0;
        try_launch = 1'b0;
        try_kind   = OP_NONE;
        try_addr   = wr_addr;
        try_len    = '0;
        clr_err    = 1'b0;
        set_bits   = '0;
        denied     = 1'b0;
        go         = 1'b0;
        upd_set    = 1'b0;
        upd_clr    = 1'b0;
        upd_master = 1'b0;
        cc         = classify(wr_data);

        if (running_q && eng_done) begin
            running_d = 1'b0;
            susp_d    = 1'b0;
            case (kind_q)
                OP_SETLK:     upd_set    = 1'b1;
                OP_CLRLK:     upd_clr    = 1'b1;
                OP_SETMASTER: upd_master = 1'b1;
                default: ;
            endcase
        end

        if (wr_en) begin
            if (running_q) begin
                if (!susp_q) begin
                    if (cc == CC_SUSP && kind_q == OP_ERASE) susp_d = 1'b1;
                end else begin
                    case (cc)
                        CC_RDARR:   mode_d = RM_ARRAY;
                        CC_IDENT:   mode_d = RM_IDENT;
                        CC_QUERY:   mode_d = RM_QUERY;
                        CC_RDSR:    mode_d = RM_STATUS;
                        CC_CONFIRM: begin susp_d = 1'b0; mode_d = RM_STATUS; end
                        default: ;
                    endcase
                end
            end else begin
                case (seq_q)
                    SQ_IDLE: begin
                        case (cc)
                            CC_RDARR: mode_d  = RM_ARRAY;
                            CC_IDENT: mode_d  = RM_IDENT;
                            CC_QUERY: mode_d  = RM_QUERY;
                            CC_RDSR:  mode_d  = RM_STATUS;
                            CC_CLRSR: clr_err = 1'b1;
                            CC_ERASE: begin seq_d = SQ_ERASE; mode_d = RM_STATUS; end
                            CC_PROG:  begin seq_d = SQ_PROG;  mode_d = RM_STATUS; end
                            CC_LOCK:  begin seq_d = SQ_LOCK;  mode_d = RM_STATUS; end
                            CC_BUF: begin
                                seq_d     = SQ_BUFCNT;
                                mode_d    = RM_STATUS;
                                bufaddr_d = wr_addr;
                            end
                            default: ;
                        endcase
                    end
                    SQ_ERASE: begin
                        seq_d = SQ_IDLE;
                        if (cc == CC_CONFIRM) begin try_launch = 1'b1; try_kind = OP_ERASE; end
                        else seq_err = 1'b1;
                    end
                    SQ_PROG: begin
                        seq_d      = SQ_IDLE;
                        try_launch = 1'b1;
                        try_kind   = OP_PROG;
                    end
                    SQ_LOCK: begin
                        seq_d = SQ_IDLE;
                        if (wr_data == SUB_SET_BLK) begin
                            try_launch = 1'b1; try_kind = OP_SETLK;
                        end else if (wr_data == CMD_CONFIRM) begin
                            try_launch = 1'b1; try_kind = OP_CLRLK;
                        end else if (wr_data == SUB_SET_MST) begin
                            try_launch = 1'b1; try_kind = OP_SETMASTER;
                        end else seq_err = 1'b1;
                    end
                    SQ_BUFCNT: begin
                        if ({1'b0, wr_data} >= 9'(BUF_BYTES)) begin
                            seq_d   = SQ_IDLE;
                            seq_err = 1'b1;
                        end else begin
                            left_d   = LEN_W'({1'b0, wr_data} + 9'd1);
                            buflen_d = LEN_W'({1'b0, wr_data} + 9'd1);
                            seq_d    = SQ_BUFDATA;
                        end
                    end
                    SQ_BUFDATA: begin
                        left_d = left_q - LEN_W'(1);
                        if (left_q == LEN_W'(1)) seq_d = SQ_BUFCONF;
                    end
                    SQ_BUFCONF: begin
                        seq_d = SQ_IDLE;
                        if (cc == CC_CONFIRM) begin
                            try_launch = 1'b1;
                            try_kind   = OP_BUFPROG;
                            try_addr   = bufaddr_q;
                            try_len    = buflen_q;
                        end else seq_err = 1'b1;
                    end
                    default: seq_d = SQ_IDLE;
                endcase
            end
        end

        if (seq_err) begin
            set_bits = SRB_ERASE_ERR | SRB_PROG_ERR;
            mode_d   = RM_STATUS;
        end

        if (try_launch) begin
            mode_d = RM_STATUS;
            case (try_kind)
                OP_ERASE, OP_PROG, OP_BUFPROG: denied = lk_hit && !hv_override;
                OP_SETLK, OP_CLRLK:            denied = master_lk && !hv_override;
                OP_SETMASTER:                  denied = !hv_override;
                default:                       denied = 1'b0;
            endcase
            if (!prog_en)    set_bits = fail_bit(try_kind) | SRB_SUPPLY;
            else if (denied) set_bits = fail_bit(try_kind) | SRB_LOCKED;
            else begin
                go        = 1'b1;
                running_d = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            seq_q     <= SQ_IDLE;
            mode_q    <= RM_ARRAY;
            running_q <= 1'b0;
            susp_q    <= 1'b0;
            start_q   <= 1'b0;
            kind_q    <= OP_NONE;
            addr_q    <= '0;
            data_q    <= '0;
            len_q     <= '0;
            left_q    <= '0;
            buflen_q  <= '0;
            bufaddr_q <= '0;
        end else begin
            seq_q     <= seq_d;
            mode_q    <= mode_d;
            running_q <= running_d;
            susp_q    <= susp_d;
            start_q   <= go;
            left_q    <= left_d;
            buflen_q  <= buflen_d;
            bufaddr_q <= bufaddr_d;
            if (go) begin
                kind_q <= try_kind;
                addr_q <= try_addr;
                data_q <= wr_data;
                len_q  <= try_len;
            end
        end
    end

    assign read_mode = mode_q;
    assign op_start  = start_q;
    assign op_kind   = kind_q;
    assign op_addr   = addr_q;
    assign op_data   = data_q;
    assign op_len    = len_q;
    assign op_hold   = susp_q;

    AST_START_NEEDS_SUPPLY: assert property (@(posedge clk) disable iff (rst)
        op_start |-> $past(prog_en)); // R8
    AST_START_SHOWS_BUSY: assert property (@(posedge clk) disable iff (rst)
        op_start |-> !status[7]); // R9
    AST_LOCKED_NO_ARRAY_OP: assert property (@(posedge clk) disable iff (rst)
        (op_start && (op_kind == 3'(OP_ERASE) || op_kind == 3'(OP_PROG)) && !$past(hv_override))
            |-> !$past(lk_hit)); // R7
    AST_HOLD_ONLY_ERASE: assert property (@(posedge clk) disable iff (rst)
        op_hold |-> (op_kind == 3'(OP_ERASE))); // R12
    AST_BUF_LEN_RANGE: assert property (@(posedge clk) disable iff (rst)
        (op_start && op_kind == 3'(OP_BUFPROG)) |-> (op_len != '0 && op_len <= LEN_W'(BUF_BYTES))); // R6

endmodule

// File: tb/flash_cmd_seq_tb.sv
module flash_cmd_seq_tb;

    localparam int CLK_PERIOD = 10;
    localparam int AW   = 20;
    localparam int NB   = 8;
    localparam int BUFB = 8;
    localparam int LW   = $clog2(BUFB + 1);

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          wr_en = 1'b0;
    logic [AW-1:0] wr_addr = '0;
    logic [7:0]    wr_data = '0;
    logic          prog_en = 1'b1;
    logic          hv_override = 1'b0;
    logic          eng_done = 1'b0;
    logic [1:0]    read_mode;
    logic          op_start;
    logic [2:0]    op_kind;
    logic [AW-1:0] op_addr;
    logic [7:0]    op_data;
    logic [LW-1:0] op_len;
    logic          op_hold;
    logic [7:0]    status;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    flash_cmd_seq #(.ADDR_W(AW), .NBLK(NB), .BUF_BYTES(BUFB)) u_dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .prog_en(prog_en), .hv_override(hv_override), .eng_done(eng_done),
        .read_mode(read_mode), .op_start(op_start), .op_kind(op_kind), .op_addr(op_addr),
        .op_data(op_data), .op_len(op_len), .op_hold(op_hold), .status(status)
    );

    function automatic logic [AW-1:0] blk(input int k, input int off);
        return AW'((k << 17) + off);
    endfunction

    function automatic logic [1:0] mode_after(input logic [7:0] c, input logic [1:0] prev);
        case (c)
            8'hFF: return 2'd0;
            8'h90: return 2'd1;
            8'h98: return 2'd2;
            8'h70: return 2'd3;
            default: return prev;
        endcase
    endfunction

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic finish_op;
        @(negedge clk);
        eng_done = 1'b1;
        @(negedge clk);
        eng_done = 1'b0;
    endtask

    task automatic summary;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        repeat (60000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        summary();
    end

    initial begin
        logic [1:0] exp_mode;
        void'($urandom(32'd4711));
        repeat (3) @(negedge clk);
        chk("R1", "mode in reset", 32'(read_mode), 0);
        chk("R1", "status in reset", 32'(status), 32'h80);
        rst = 1'b0;
        @(negedge clk);
        chk("R1", "mode after reset", 32'(read_mode), 0);
        chk("R1", "status after reset", 32'(status), 32'h80);
        chk("R1", "no start", 32'(op_start), 0);
        chk("R1", "no hold", 32'(op_hold), 0);

        // R2 read modes
        wr(0, 8'h90); chk("R2", "ident", 32'(read_mode), 1);
        wr(0, 8'h98); chk("R2", "query", 32'(read_mode), 2);
        wr(0, 8'h70); chk("R2", "status mode", 32'(read_mode), 3);
        wr(0, 8'hFF); chk("R2", "array", 32'(read_mode), 0);
        wr(0, 8'h33); chk("R2", "unknown byte keeps mode", 32'(read_mode), 0);

        // R3 erase, R12 suspend, R13 busy writes
        wr(blk(2, 0), 8'h20);
        chk("R3", "mode status after first cycle", 32'(read_mode), 3);
        chk("R3", "no start after first cycle", 32'(op_start), 0);
        wr(blk(2, 5), 8'hD0);
        chk("R3", "erase start", 32'(op_start), 1);
        chk("R3", "erase kind", 32'(op_kind), 1);
        chk("R3", "erase addr", 32'(op_addr), 32'(blk(2, 5)));
        chk("R9", "busy status", 32'(status), 32'h00);
        @(negedge clk);
        chk("R3", "start is one cycle", 32'(op_start), 0);
        wr(0, 8'hFF);
        chk("R13", "mode kept while busy", 32'(read_mode), 3);
        wr(0, 8'h50);
        chk("R13", "status kept while busy", 32'(status), 32'h00);
        wr(0, 8'hB0);
        chk("R12", "suspended status", 32'(status), 32'hC0);
        chk("R12", "hold raised", 32'(op_hold), 1);
        wr(0, 8'h90);
        chk("R12", "read mode during suspend", 32'(read_mode), 1);
        wr(0, 8'hD0);
        chk("R12", "resumed status", 32'(status), 32'h00);
        chk("R12", "hold dropped", 32'(op_hold), 0);
        chk("R12", "mode after resume", 32'(read_mode), 3);
        finish_op();
        chk("R9", "ready after done", 32'(status), 32'h80);

        // R4 program, both opcodes
        wr(blk(1, 12), 8'h40);
        wr(blk(1, 13), 8'h5A);
        chk("R4", "program start", 32'(op_start), 1);
        chk("R4", "program kind", 32'(op_kind), 2);
        chk("R4", "program addr", 32'(op_addr), 32'(blk(1, 13)));
        chk("R4", "program data", 32'(op_data), 32'h5A);
        finish_op();
        wr(blk(6, 3), 8'h10);
        wr(blk(6, 3), 8'hA5);
        chk("R4", "alt program data", 32'(op_data), 32'hA5);
        wr(0, 8'hB0);
        chk("R12", "suspend ignored on program", 32'(status), 32'h00);
        chk("R12", "no hold on program", 32'(op_hold), 0);
        finish_op();
        chk("R9", "ready after program", 32'(status), 32'h80);

        // R5 / R7 block lock
        wr(blk(3, 0), 8'h60);
        wr(blk(3, 0), 8'h01);
        chk("R5", "set lock start", 32'(op_start), 1);
        chk("R5", "set lock kind", 32'(op_kind), 4);
        finish_op();
        wr(blk(3, 8), 8'h20);
        wr(blk(3, 8), 8'hD0);
        chk("R7", "locked erase refused", 32'(op_start), 0);
        chk("R7", "locked erase status", 32'(status), 32'hA2);
        wr(0, 8'h50);
        chk("R11", "clear status", 32'(status), 32'h80);
        hv_override = 1'b1;
        wr(blk(3, 8), 8'h20);
        wr(blk(3, 8), 8'hD0);
        chk("R7", "override erase starts", 32'(op_start), 1);
        finish_op();
        hv_override = 1'b0;
        wr(blk(3, 2), 8'h40);
        wr(blk(3, 2), 8'h77);
        chk("R7", "locked program refused", 32'(op_start), 0);
        chk("R7", "locked program status", 32'(status), 32'h92);
        wr(0, 8'h70);
        chk("R11", "error sticky", 32'(status), 32'h92);
        wr(0, 8'h50);

        // master lock
        wr(0, 8'h60);
        wr(0, 8'hF1);
        chk("R7", "master needs override", 32'(op_start), 0);
        chk("R7", "master refusal status", 32'(status), 32'h92);
        wr(0, 8'h50);
        hv_override = 1'b1;
        wr(0, 8'h60);
        wr(0, 8'hF1);
        chk("R5", "master set start", 32'(op_kind), 6);
        finish_op();
        hv_override = 1'b0;
        wr(blk(4, 0), 8'h60);
        wr(blk(4, 0), 8'h01);
        chk("R7", "master blocks set lock", 32'(status), 32'h92);
        wr(0, 8'h50);
        hv_override = 1'b1;
        wr(0, 8'h60);
        wr(0, 8'hD0);
        chk("R5", "clear locks kind", 32'(op_kind), 5);
        chk("R5", "clear locks start", 32'(op_start), 1);
        finish_op();
        hv_override = 1'b0;
        wr(blk(3, 1), 8'h20);
        wr(blk(3, 1), 8'hD0);
        chk("R5", "erase after clear starts", 32'(op_start), 1);
        finish_op();
        wr(blk(4, 1), 8'h40);
        wr(blk(4, 1), 8'h11);
        chk("R7", "refused lock left block open", 32'(op_start), 1);
        finish_op();

        // R8 supply low
        prog_en = 1'b0;
        wr(blk(5, 0), 8'h20);
        wr(blk(5, 0), 8'hD0);
        chk("R8", "erase without supply", 32'(status), 32'hA8);
        chk("R8", "no start", 32'(op_start), 0);
        wr(0, 8'h50);
        wr(blk(5, 0), 8'h40);
        wr(blk(5, 0), 8'h12);
        chk("R8", "program without supply", 32'(status), 32'h98);
        wr(0, 8'h50);
        prog_en = 1'b1;

        // R10 sequence errors
        wr(0, 8'hFF);
        wr(blk(1, 0), 8'h20);
        wr(blk(1, 0), 8'h33);
        chk("R10", "bad erase confirm", 32'(status), 32'hB0);
        chk("R10", "mode status", 32'(read_mode), 3);
        chk("R10", "no start", 32'(op_start), 0);
        wr(0, 8'h50);
        wr(0, 8'h60);
        wr(0, 8'h77);
        chk("R10", "bad lock sub", 32'(status), 32'hB0);
        wr(0, 8'h50);

        // R6 buffered program
        wr(blk(1, 4), 8'hE8);
        wr(blk(1, 4), 8'h03);
        wr(blk(1, 4), 8'h11);
        wr(blk(1, 5), 8'hD0);
        chk("R6", "data D0 not a confirm", 32'(op_start), 0);
        wr(blk(1, 6), 8'h22);
        wr(blk(1, 7), 8'h33);
        chk("R6", "no start before confirm", 32'(op_start), 0);
        wr(blk(1, 4), 8'hD0);
        chk("R6", "buffer start", 32'(op_start), 1);
        chk("R6", "buffer kind", 32'(op_kind), 3);
        chk("R6", "buffer len", 32'(op_len), 4);
        chk("R6", "buffer addr", 32'(op_addr), 32'(blk(1, 4)));
        finish_op();
        wr(0, 8'hE8);
        wr(0, 8'h08);
        chk("R6", "oversize count", 32'(status), 32'hB0);
        wr(0, 8'h50);
        wr(blk(2, 0), 8'hE8);
        wr(blk(2, 0), 8'h07);
        for (int i = 0; i < 8; i++) wr(blk(2, i), 8'(i));
        wr(blk(2, 0), 8'hD0);
        chk("R6", "full buffer len", 32'(op_len), 8);
        finish_op();
        wr(0, 8'hE8);
        wr(0, 8'h00);
        wr(0, 8'h99);
        wr(0, 8'h44);
        chk("R10", "bad buffer confirm", 32'(status), 32'hB0);
        wr(0, 8'h50);

        // random read-mode commands
        exp_mode = read_mode;
        for (int i = 0; i < 40; i++) begin
            logic [7:0] c;
            case ($urandom_range(0, 4))
                0: c = 8'hFF;
                1: c = 8'h90;
                2: c = 8'h98;
                3: c = 8'h70;
                default: c = 8'h50;
            endcase
            wr(AW'($urandom), c);
            exp_mode = mode_after(c, exp_mode);
            chk("R2", "random mode", 32'(read_mode), 32'(exp_mode));
        end

        // random programs
        for (int i = 0; i < 10; i++) begin
            logic [AW-1:0] a;
            logic [7:0] d;
            a = AW'($urandom);
            d = 8'($urandom);
            wr(a, ($urandom_range(0, 1) == 0) ? 8'h40 : 8'h10);
            wr(a, d);
            chk("R4", "random program addr", 32'(op_addr), 32'(a));
            chk("R4", "random program data", 32'(op_data), 32'(d));
            finish_op();
            chk("R9", "random program done", 32'(status), 32'h80);
        end

        summary();
    end

endmodule